// File: doc/BRIEF.md
# Dual Flash Bank Boot Remapper

This block places two independent flash banks, a large primary bank and a small secondary bank, into a CPU address window. A boot-select bit, held in storage that models non-volatile configuration, decides which bank sits at address zero when the CPU leaves reset. The other bank stays disabled until firmware gives it a start address and a size and turns it on. Only a debug-port write followed by a commit pulse can alter the boot-select bit. The new value takes effect at the next CPU reset.

Each read presents an address with `rd_en`. The block answers in the same cycle with a one-hot bank select and the offset inside that bank. If no enabled bank claims the address, it raises a decode error. If the winning bank is being programmed or erased, it raises a stall instead of a select. A read that lands on the idle bank proceeds while the other bank is busy. If the two ranges overlap, the bank that booted owns the shared addresses. Firmware writes and reads the configuration through a small register port. `por_n` loads the factory boot value into the configuration store. `rst_n` is the CPU reset. It is asynchronous on assertion and is released in step with the clock.

Top module: `flash_boot_remap`

## Requirements
- R1: With the stored boot-select at 0, a CPU reset leaves the primary bank enabled at base 0 with size 2^PRI_LOG. The secondary bank is disabled, with base 0 and size 2^SEC_LOG. The enable register reads 2'b01 and the boot status reads 2'b00.
- R2: With the stored boot-select at 1, a CPU reset leaves the secondary bank enabled at base 0 and the primary bank disabled. The enable register reads 2'b10 and the boot status reads 2'b11.
- R3: Register port writes to index 5 do not change either boot bit. The stored bit changes only when a debug write (`dbg_we`, `dbg_wdata`) is followed by a `dbg_commit` pulse. A commit with no pending write does nothing. The active bit (status bit 1) takes the stored bit (status bit 0) only at a CPU reset, and the stored bit survives that reset.
- R4: The register map, by `cfg_addr`, is: 0 primary base, 1 primary size, 2 secondary base, 3 secondary size, 4 enables, 5 boot status. In the enable register, bit 0 is the primary bank and bit 1 is the secondary bank. In the boot status, bit 1 is the active bit and bit 0 is the stored bit. Writes take effect at the next clock edge. Reads are combinational. Other indices read 0.
- R5: A size write is accepted only when the value is a power of two no larger than that bank's maximum (2^PRI_LOG or 2^SEC_LOG). Any other size write leaves the size unchanged.
- R6: The effective base of a bank is the written base rounded down to a multiple of its size. Read-back returns the effective base.
- R7: A read whose address falls in exactly one enabled bank's range asserts that bank's select. `rd_offset` equals the address minus the effective base.
- R8: A read that no enabled bank claims asserts `dec_err` with no select, no stall and offset 0.
- R9: When both enabled ranges contain the address, the bank that is active as the boot bank is selected.
- R10: When the winning bank's busy input is high, `rd_stall` is asserted and neither select is asserted. Busy on the other bank has no effect on the read.
- R11: With `rd_en` low, all select, error, stall and offset outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on load of the configuration store, active low |
| rst_n | input | 1 | CPU reset, active low, asynchronous assertion |
| cfg_we | input | 1 | Register port write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data |
| dbg_we | input | 1 | Debug-port write of the boot-select value |
| dbg_wdata | input | 1 | Boot-select value to stage |
| dbg_commit | input | 1 | Commit pulse that stores the staged value |
| pri_busy | input | 1 | Primary bank program/erase in progress |
| sec_busy | input | 1 | Secondary bank program/erase in progress |
| rd_en | input | 1 | Read request valid |
| rd_addr | input | ADDR_W | Read address |
| sel_pri | output | 1 | Read goes to the primary bank |
| sel_sec | output | 1 | Read goes to the secondary bank |
| rd_offset | output | ADDR_W | Offset within the selected bank |
| dec_err | output | 1 | No enabled bank claims the address |
| rd_stall | output | 1 | Winning bank is busy |

## Verification
A read can arrive in the same cycle as a program/erase busy flag on the bank it targets or on the other bank. Overlap priority can also coincide with that busy state. The full address space is swept with each busy flag tied to a different address bit. Every combination of overlap and busy therefore occurs within each sweep, under both boot-bank choices. Each response is compared with an arithmetic model of the ranges, the priority and the stall rule.

// File: rtl/flash_remap_pkg.sv
package flash_remap_pkg;
  localparam int unsigned NBANK    = 2;
  localparam int unsigned BANK_PRI = 0;
  localparam int unsigned BANK_SEC = 1;

  typedef enum logic [2:0] {
    REG_PRI_BASE = 3'd0,
    REG_PRI_SIZE = 3'd1,
    REG_SEC_BASE = 3'd2,
    REG_SEC_SIZE = 3'd3,
    REG_ENABLE   = 3'd4,
    REG_BOOT     = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/frm_rst_sync.sv
module frm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/frm_boot_nv.sv
module frm_boot_nv #(
  parameter logic BOOT_DEFAULT = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic dbg_we,
  input  logic dbg_wdata,
  input  logic dbg_commit,
  output logic nv_boot
);
  logic stage_q, stage_d, pend_q, pend_d, nv_q, nv_d;

  always_comb begin
    stage_d = stage_q;
    pend_d  = pend_q;
    nv_d    = nv_q;
    if (dbg_commit && pend_q) begin
      nv_d   = stage_q;
      pend_d = 1'b0;
    end
    if (dbg_we) begin
      stage_d = dbg_wdata;
      pend_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stage_q <= BOOT_DEFAULT;
      pend_q  <= 1'b0;
      nv_q    <= BOOT_DEFAULT;
    end else begin
      stage_q <= stage_d;
      pend_q  <= pend_d;
      nv_q    <= nv_d;
    end
  end

  assign nv_boot = nv_q;

  // R3: the stored bit moves only on a commit that follows a staged write
  a_r3_nv_needs_commit: assert property (@(posedge clk) disable iff (!por_n)
    (!dbg_commit || !pend_q) |=> $stable(nv_q));
endmodule

// File: rtl/frm_cfg_regs.sv
module frm_cfg_regs
  import flash_remap_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          PRI_LOG      = 10,
  parameter int          SEC_LOG      = 8,
  parameter logic        BOOT_DEFAULT = 1'b0
) (
  input  logic                          clk,
  input  logic                          por_n,
  input  logic                          rst_sync_n,
  input  logic                          nv_boot,
  input  logic                          cfg_we,
  input  logic [2:0]                    cfg_addr,
  input  logic [ADDR_W-1:0]             cfg_wdata,
  output logic [ADDR_W-1:0]             cfg_rdata,
  output logic                          boot_act,
  output logic [NBANK-1:0][ADDR_W-1:0]  base_o,
  output logic [NBANK-1:0][ADDR_W-1:0]  mask_o,
  output logic [NBANK-1:0]              en_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  function automatic logic size_ok(input logic [ADDR_W-1:0] v, input int lg);
    return (v != '0) && ((v & (v - ONE)) == '0) && (v <= (ONE << lg));
  endfunction

  logic [NBANK-1:0][ADDR_W-1:0] size_w;

  // active boot bank: follows the stored bit while the CPU reset is held
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           boot_act <= BOOT_DEFAULT;
    else if (!rst_sync_n) boot_act <= nv_boot;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int          LG       = (b == BANK_PRI) ? PRI_LOG : SEC_LOG;
    localparam logic [2:0]  IDX_BASE = (b == BANK_PRI) ? REG_PRI_BASE : REG_SEC_BASE;
    localparam logic [2:0]  IDX_SIZE = (b == BANK_PRI) ? REG_PRI_SIZE : REG_SEC_SIZE;
    localparam logic [ADDR_W-1:0] SZ_RST = ONE << LG;

    logic [ADDR_W-1:0] base_q, size_q;
    logic              base_ce, size_ce;

    assign base_ce = cfg_we && (cfg_addr == IDX_BASE);
    assign size_ce = cfg_we && (cfg_addr == IDX_SIZE) && size_ok(cfg_wdata, LG);

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        base_q <= '0;
        size_q <= SZ_RST;
      end else begin
        if (base_ce) base_q <= cfg_wdata;
        if (size_ce) size_q <= cfg_wdata;
      end
    end

    assign size_w[b] = size_q;
    assign mask_o[b] = size_q - ONE;
    assign base_o[b] = base_q & ~(size_q - ONE);

    // R5: a stored size is always a single power of two within the bank limit
    a_r5_size_pow2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ($countones(size_q) == 1) && (size_q <= SZ_RST));
  end

  // enables are kept relative to the boot bank so reset values are constant
  logic en_boot_q, en_oth_q, en_boot_d, en_oth_d, en_ce;
  assign en_ce = cfg_we && (cfg_addr == REG_ENABLE);

  always_comb begin
    en_boot_d = boot_act ? cfg_wdata[1] : cfg_wdata[0];
    en_oth_d  = boot_act ? cfg_wdata[0] : cfg_wdata[1];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_boot_q <= 1'b1;
      en_oth_q  <= 1'b0;
    end else if (en_ce) begin
      en_boot_q <= en_boot_d;
      en_oth_q  <= en_oth_d;
    end
  end

  assign en_o[BANK_PRI] = boot_act ? en_oth_q  : en_boot_q;
  assign en_o[BANK_SEC] = boot_act ? en_boot_q : en_oth_q;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_PRI_BASE: cfg_rdata = base_o[BANK_PRI];
      REG_PRI_SIZE: cfg_rdata = size_w[BANK_PRI];
      REG_SEC_BASE: cfg_rdata = base_o[BANK_SEC];
      REG_SEC_SIZE: cfg_rdata = size_w[BANK_SEC];
      REG_ENABLE:   cfg_rdata[1:0] = en_o;
      REG_BOOT:     cfg_rdata[1:0] = {boot_act, nv_boot};
      default:      cfg_rdata = '0;
    endcase
  end

  // R1: the active boot bank holds still once the CPU reset is released
  a_r1_boot_hold: assert property (@(posedge clk) disable iff (!rst_sync_n || !por_n)
    $past(rst_sync_n) |-> $stable(boot_act));
endmodule

// File: rtl/frm_bank_match.sv
module frm_bank_match #(
  parameter int ADDR_W = 12
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  assign hit    = en && ((addr & ~mask) == base);
  assign offset = addr & mask;
endmodule

// File: rtl/flash_boot_remap.sv
module flash_boot_remap
  import flash_remap_pkg::*;
#(
  parameter int   ADDR_W       = 12,
  parameter int   PRI_LOG      = 10,
  parameter int   SEC_LOG      = 8,
  parameter logic BOOT_DEFAULT = 1'b0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              dbg_we,
  input  logic              dbg_wdata,
  input  logic              dbg_commit,
  input  logic              pri_busy,
  input  logic              sec_busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              sel_pri,
  output logic              sel_sec,
  output logic [ADDR_W-1:0] rd_offset,
  output logic              dec_err,
  output logic              rd_stall
);
  logic                         rst_sync_n, nv_boot, boot_act;
  logic [NBANK-1:0][ADDR_W-1:0] base_w, mask_w, off_w;
  logic [NBANK-1:0]             en_w, hit_w, busy_w, win_w;

  frm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  frm_boot_nv #(.BOOT_DEFAULT(BOOT_DEFAULT)) u_nv (
    .clk(clk), .por_n(por_n), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .dbg_commit(dbg_commit), .nv_boot(nv_boot));

  frm_cfg_regs #(.ADDR_W(ADDR_W), .PRI_LOG(PRI_LOG), .SEC_LOG(SEC_LOG),
                 .BOOT_DEFAULT(BOOT_DEFAULT)) u_cfg (
    .clk(clk), .por_n(por_n), .rst_sync_n(rst_sync_n), .nv_boot(nv_boot),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .boot_act(boot_act), .base_o(base_w),
    .mask_o(mask_w), .en_o(en_w));

  for (genvar b = 0; b < NBANK; b++) begin : g_match
    frm_bank_match #(.ADDR_W(ADDR_W)) u_match (
      .en(en_w[b]), .addr(rd_addr), .base(base_w[b]), .mask(mask_w[b]),
      .hit(hit_w[b]), .offset(off_w[b]));
  end

  assign busy_w = {sec_busy, pri_busy};

  // overlap: the active boot bank wins
  always_comb begin
    win_w[BANK_PRI] = hit_w[BANK_PRI] && (!hit_w[BANK_SEC] || !boot_act);
    win_w[BANK_SEC] = hit_w[BANK_SEC] && (!hit_w[BANK_PRI] ||  boot_act);
  end

  always_comb begin
    sel_pri   = 1'b0;
    sel_sec   = 1'b0;
    rd_offset = '0;
    dec_err   = 1'b0;
    rd_stall  = 1'b0;
    if (rd_en) begin
      if (win_w == '0) begin
        dec_err = 1'b1;
      end else if ((win_w & busy_w) != '0) begin
        rd_stall = 1'b1;
      end else begin
        sel_pri   = win_w[BANK_PRI];
        sel_sec   = win_w[BANK_SEC];
        rd_offset = win_w[BANK_PRI] ? off_w[BANK_PRI] : off_w[BANK_SEC];
      end
    end
  end

  // R11: no activity without a request
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |-> !(sel_pri || sel_sec || dec_err || rd_stall) && (rd_offset == '0));
  // R8: an error excludes every other response
  a_r8_err_alone: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dec_err |-> !sel_pri && !sel_sec && !rd_stall);
  // R10: a busy bank is never selected
  a_r10_busy_pri_nosel: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pri_busy |-> !sel_pri);
  a_r10_busy_sec_nosel: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sec_busy |-> !sel_sec);
  // R10: a stall only happens while some bank is busy
  a_r10_stall_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_stall |-> (pri_busy || sec_busy));
  // R7: at most one bank selected
  a_r7_one_sel: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({sel_pri, sel_sec}));
endmodule

// File: tb/sim_flash_boot_remap.sv
module sim_flash_boot_remap;
  localparam int AW  = 12;
  localparam int PLG = 10;
  localparam int SLG = 8;

  logic          clk = 1'b0;
  logic          por_n, rst_n, cfg_we, dbg_we, dbg_wdata, dbg_commit;
  logic          pri_busy, sec_busy, rd_en;
  logic [2:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata, cfg_rdata, rd_addr, rd_offset;
  logic          sel_pri, sel_sec, dec_err, rd_stall;

  int checks = 0;
  int errs   = 0;

  // bench-side model of the configuration
  logic [AW-1:0] m_base [2];
  logic [AW-1:0] m_size [2];
  logic          m_en   [2];
  logic          m_boot, m_nv, m_stage, m_pend;

  always #2 clk = ~clk;

  flash_boot_remap #(.ADDR_W(AW), .PRI_LOG(PLG), .SEC_LOG(SLG), .BOOT_DEFAULT(1'b0)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dbg_we(dbg_we),
    .dbg_wdata(dbg_wdata), .dbg_commit(dbg_commit), .pri_busy(pri_busy),
    .sec_busy(sec_busy), .rd_en(rd_en), .rd_addr(rd_addr), .sel_pri(sel_pri),
    .sel_sec(sel_sec), .rd_offset(rd_offset), .dec_err(dec_err), .rd_stall(rd_stall));

  initial begin
    #(4 * 190000);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_boot    = m_nv;
    m_base[0] = '0; m_base[1] = '0;
    m_size[0] = AW'(1) << PLG;
    m_size[1] = AW'(1) << SLG;
    m_en[0]   = !m_nv;
    m_en[1]   = m_nv;
  endtask

  task automatic cpu_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [AW-1:0] d);
    int lg;
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    case (a)
      3'd0: m_base[0] = d;
      3'd2: m_base[1] = d;
      3'd1, 3'd3: begin
        lg = (a == 3'd1) ? PLG : SLG;
        if (d != 0 && (d & (d - 1)) == 0 && d <= (AW'(1) << lg)) m_size[a >> 1] = d;
      end
      3'd4: begin m_en[0] = d[0]; m_en[1] = d[1]; end
      default: ;
    endcase
  endtask

  task automatic dbg_write(input logic v);
    @(negedge clk); dbg_we = 1'b1; dbg_wdata = v;
    @(negedge clk); dbg_we = 1'b0;
    m_stage = v; m_pend = 1'b1;
  endtask

  task automatic dbg_pulse();
    @(negedge clk); dbg_commit = 1'b1;
    @(negedge clk); dbg_commit = 1'b0;
    if (m_pend) begin m_nv = m_stage; m_pend = 1'b0; end
  endtask

  task automatic read_reg(input string tag, input logic [2:0] a, input logic [AW-1:0] exp);
    @(negedge clk); cfg_addr = a; #1;
    check(tag, 32'(cfg_rdata), 32'(exp));
  endtask

  function automatic logic m_hit(input int b, input logic [AW-1:0] a);
    logic [AW-1:0] al;
    al = ~(m_size[b] - 1);
    return m_en[b] && ((a & al) == (m_base[b] & al));
  endfunction

  task automatic check_read(input string pre);
    logic hp, hs, w, bsy;
    logic [31:0] exp, act;
    string t;
    hp = m_hit(0, rd_addr);
    hs = m_hit(1, rd_addr);
    exp = '0;
    if (!rd_en) t = "R11";
    else if (!hp && !hs) begin t = "R8"; exp[1] = 1'b1; end
    else begin
      w   = (hp && hs) ? m_boot : !hp;
      bsy = w ? sec_busy : pri_busy;
      if (bsy) begin t = "R10"; exp[0] = 1'b1; end
      else begin
        t = (hp && hs) ? "R9" : "R7";
        exp[3] = !w; exp[2] = w;
        exp[31:16] = 16'(rd_addr & (m_size[w] - 1));
      end
    end
    act = {16'(rd_offset), 12'd0, sel_pri, sel_sec, dec_err, rd_stall};
    check({pre, "/", t}, act, exp);
  endtask

  task automatic sweep(input string pre, input bit en, input bit busy_mix);
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      rd_en    = en;
      rd_addr  = AW'(a);
      pri_busy = busy_mix & a[3];
      sec_busy = busy_mix & a[6];
      #1;
      check_read(pre);
    end
    @(negedge clk); rd_en = 1'b0; pri_busy = 1'b0; sec_busy = 1'b0;
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    dbg_we = 1'b0; dbg_wdata = 1'b0; dbg_commit = 1'b0;
    pri_busy = 1'b0; sec_busy = 1'b0; rd_en = 1'b0; rd_addr = '0;
    m_nv = 1'b0; m_stage = 1'b0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();

    // R1 reset state with default boot-select
    read_reg("R1 pri base", 3'd0, 12'h000);
    read_reg("R1 pri size", 3'd1, 12'd1024);
    read_reg("R1 sec size", 3'd3, 12'd256);
    read_reg("R1 enables",  3'd4, 12'h001);
    read_reg("R1 boot",     3'd5, 12'h000);
    sweep("R1", 1'b1, 1'b0);

    // R3 register port cannot touch the boot bit
    cfg_write(3'd5, 12'hFFF);
    read_reg("R3 cpu write ignored", 3'd5, 12'h000);

    // R5 size acceptance
    cfg_write(3'd1, 12'd300);
    read_reg("R5 non pow2 ignored", 3'd1, 12'd1024);
    cfg_write(3'd1, 12'd2048);
    read_reg("R5 over max ignored", 3'd1, 12'd1024);
    cfg_write(3'd3, 12'd512);
    read_reg("R5 sec over max ignored", 3'd3, 12'd256);
    cfg_write(3'd1, 12'd512);
    read_reg("R5 accepted", 3'd1, 12'd512);

    // R4 and R6 relocation with rounding
    cfg_write(3'd2, 12'h3C5);
    read_reg("R6 sec base rounded", 3'd2, 12'h300);
    cfg_write(3'd4, 12'h003);
    read_reg("R4 enables", 3'd4, 12'h003);
    read_reg("R4 unused index", 3'd7, 12'h000);
    sweep("R4", 1'b1, 1'b1);

    // R9 overlap, primary boots
    cfg_write(3'd2, 12'h1FF);
    read_reg("R6 sec base rounded", 3'd2, 12'h100);
    sweep("R9", 1'b1, 1'b1);

    // R11 idle
    sweep("R11", 1'b0, 1'b1);

    // R3 debug path
    dbg_pulse();
    read_reg("R3 commit without write", 3'd5, 12'h000);
    dbg_write(1'b1);
    read_reg("R3 staged not stored", 3'd5, 12'h000);
    dbg_pulse();
    read_reg("R3 stored not active", 3'd5, 12'h001);
    cpu_reset();
    read_reg("R3 active after reset", 3'd5, 12'h003);

    // R2 alternate boot
    read_reg("R2 enables", 3'd4, 12'h002);
    read_reg("R2 sec base", 3'd2, 12'h000);
    read_reg("R2 pri size", 3'd1, 12'd1024);
    sweep("R2", 1'b1, 1'b0);

    // R9 overlap, secondary boots, plus busy
    cfg_write(3'd4, 12'h003);
    read_reg("R4 enables alt", 3'd4, 12'h003);
    sweep("R9", 1'b1, 1'b1);
    cfg_write(3'd0, 12'h7FF);
    read_reg("R6 pri base rounded", 3'd0, 12'h400);
    sweep("R7", 1'b1, 1'b1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule